// File: doc/BRIEF.md
# Port Link Capability and Status Generator

This block produces the link-related register words of a PCI Express root or downstream port. From two static configuration inputs, the maximum lane count and the maximum speed code, it derives the link capability word, the second link capability word with its supported-speed vector, and the target-speed field of the second link control word. The optional capability bits for bandwidth notification and link-active reporting follow from these two values alone.

The block also mirrors the link that the device below the port has trained. When an update strobe arrives and a device is present, the block takes that device's link status word and sanitises it. A width or speed larger than the port supports is cut down to the port's maximum. A zero field is raised to the minimum, one lane at the lowest speed. The result goes into the port's own link status register. Only the width and speed fields of that register are written. Every other bit keeps its value.

Top module: `lnk_capsta_top`

## Requirements
- R1: `link_cap` bits 3:0 equal `cfg_max_speed`, bits 9:4 equal `cfg_max_width`, bit 10 (L0s support) is 1 and bits 31:24 equal the port-number parameter. All other bits are 0 unless R2 or R3 sets them.
- R2: `link_cap` bit 21 (bandwidth notification capable) is 1 exactly when `cfg_max_width` > 1 or `cfg_max_speed` > 1.
- R3: `link_cap` bit 20 (link-active reporting capable) is 1 exactly when `cfg_max_speed` > 1.
- R4: `link_ctl2` bits 3:0 (target speed) equal `cfg_max_speed`. All its other bits are 0.
- R5: If `cfg_max_speed` >= 3, `link_cap2` has bits 1, 2 and 3 set, and it also has bit 4 set when `cfg_max_speed` >= 4. If `cfg_max_speed` < 3, `link_cap2` is 0. Speed codes are 1 = 2.5, 2 = 5, 3 = 8 and 4 = 16 GT/s, and bit k of the vector stands for code k.
- R6: After reset, `link_status` is 0x0011: width field (bits 9:4) = 1, speed field (bits 3:0) = 1, and all other bits 0.
- R7: On an accepted update, a downstream width (bits 9:4 of `dn_link_status`) greater than `cfg_max_width` is stored as `cfg_max_width`. A width that is not greater is stored as given, unless R9 applies.
- R8: On an accepted update, a downstream speed (bits 3:0) greater than `cfg_max_speed` is stored as `cfg_max_speed`. A speed that is not greater is stored as given, unless R9 applies.
- R9: On an accepted update, a downstream width field of 0 is stored as 1, and a downstream speed field of 0 is stored as 1.
- R10: An update is accepted when `sync_req` is 1 at a rising clock edge while `dn_present` is 1. Its result is visible on `link_status` right after that edge. If `dn_present` is 0, the strobe leaves `link_status` unchanged.
- R11: While `sync_req` is 0, `link_status` holds its value. A strobe asserted during reset has no effect.
- R12: Bits 15:10 of `link_status` are never taken from `dn_link_status`. They keep their value across every update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_max_width | input | 6 | Maximum lane count of the port |
| cfg_max_speed | input | 4 | Maximum speed code of the port |
| dn_present | input | 1 | A device is attached below the port |
| dn_link_status | input | 16 | Link status word read from the downstream device |
| sync_req | input | 1 | Update strobe for the mirrored status |
| link_cap | output | 32 | Link capability word |
| link_cap2 | output | 32 | Second link capability word |
| link_ctl2 | output | 16 | Second link control word |
| link_status | output | 16 | Mirrored link status word |

## Verification
The capability words are pure functions of the configuration. A wrong decode shows on `link_cap`, `link_cap2` or `link_ctl2` in the same cycle for a particular width and speed pair, so a full sweep of both inputs exposes it. The only state is the status register. A bad clamp, a missed zero substitution or a wrongly gated enable shows on `link_status` one cycle after the strobe. Any disturbance of the upper bits shows in the same cycle and then persists. For this reason every single update is compared against an arithmetic model, and updates rejected for lack of a device are compared against the value held before them.

// File: rtl/lnk_capsta_pkg.sv
package lnk_capsta_pkg;
  localparam int SPD_W       = 4;
  localparam int WID_W       = 6;
  localparam int STA_W       = 16;
  localparam int SPD_LSB     = 0;
  localparam int WID_LSB     = 4;
  localparam int L0S_BIT     = 10;
  localparam int DLLA_BIT    = 20;
  localparam int LBN_BIT     = 21;
  localparam int PNUM_LSB    = 24;
  localparam int NUM_SPD     = 4;
  localparam int SPD_2G5     = 1;
  localparam int SPD_5G      = 2;
  localparam int SPD_8G      = 3;
  localparam int FLD_TOP     = WID_LSB + WID_W;
endpackage

// File: rtl/lnk_cap_gen.sv
module lnk_cap_gen
  import lnk_capsta_pkg::*;
#(
  parameter logic [7:0] PORT_NUMBER = 8'h00
) (
  input  logic [WID_W-1:0] max_width,
  input  logic [SPD_W-1:0] max_speed,
  output logic [31:0]      cap,
  output logic [31:0]      cap2,
  output logic [15:0]      ctl2
);
  logic wide_or_fast;
  logic above_base;
  logic vec_on;
  logic [NUM_SPD:1] spd_vec;

  always_comb begin
    wide_or_fast = (max_width > WID_W'(1)) || (max_speed > SPD_W'(SPD_2G5));
    above_base   = max_speed > SPD_W'(SPD_2G5);
    vec_on       = max_speed > SPD_W'(SPD_5G);
  end

  // supported-speed vector, bit k stands for speed code k
  for (genvar k = 1; k <= NUM_SPD; k++) begin : g_spd
    if (k <= SPD_8G) begin : g_low
      assign spd_vec[k] = vec_on;
    end else begin : g_high
      assign spd_vec[k] = vec_on && (max_speed >= SPD_W'(k));
    end
  end

  always_comb begin
    cap = '0;
    cap[SPD_LSB +: SPD_W]  = max_speed;
    cap[WID_LSB +: WID_W]  = max_width;
    cap[L0S_BIT]           = 1'b1;
    cap[DLLA_BIT]          = above_base;
    cap[LBN_BIT]           = wide_or_fast;
    cap[PNUM_LSB +: 8]     = PORT_NUMBER;
    cap2 = '0;
    cap2[NUM_SPD:1]        = spd_vec;
    ctl2 = '0;
    ctl2[SPD_LSB +: SPD_W] = max_speed;
  end
endmodule

// File: rtl/lnk_field_clamp.sv
module lnk_field_clamp #(
  parameter int W = 4
) (
  input  logic [W-1:0] raw,
  input  logic [W-1:0] limit,
  output logic [W-1:0] fixed
);
  always_comb begin
    if (raw > limit)
      fixed = limit;
    else if (raw == '0)
      fixed = W'(1);
    else
      fixed = raw;
  end
endmodule

// File: rtl/lnk_sta_reg.sv
module lnk_sta_reg
  import lnk_capsta_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [WID_W-1:0] new_width,
  input  logic [SPD_W-1:0] new_speed,
  output logic [STA_W-1:0] sta_q
);
  logic [STA_W-1:0] sta_d;

  always_comb begin
    sta_d = sta_q;
    if (load_en) begin
      sta_d[WID_LSB +: WID_W] = new_width;
      sta_d[SPD_LSB +: SPD_W] = new_speed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_q                   <= '0;
      sta_q[WID_LSB +: WID_W] <= WID_W'(1);
      sta_q[SPD_LSB +: SPD_W] <= SPD_W'(SPD_2G5);
    end else if (load_en) begin
      sta_q <= sta_d;
    end
  end
endmodule

// File: rtl/lnk_capsta_top.sv
module lnk_capsta_top
  import lnk_capsta_pkg::*;
#(
  parameter logic [7:0] PORT_NUMBER = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WID_W-1:0] cfg_max_width,
  input  logic [SPD_W-1:0] cfg_max_speed,
  input  logic             dn_present,
  input  logic [STA_W-1:0] dn_link_status,
  input  logic             sync_req,
  output logic [31:0]      link_cap,
  output logic [31:0]      link_cap2,
  output logic [15:0]      link_ctl2,
  output logic [STA_W-1:0] link_status
);
  logic [WID_W-1:0] width_fix;
  logic [SPD_W-1:0] speed_fix;
  logic             take;

  lnk_cap_gen #(.PORT_NUMBER(PORT_NUMBER)) u_cap (
    .max_width (cfg_max_width),
    .max_speed (cfg_max_speed),
    .cap       (link_cap),
    .cap2      (link_cap2),
    .ctl2      (link_ctl2)
  );

  // limits are the fields the port itself advertises
  lnk_field_clamp #(.W(WID_W)) u_wclamp (
    .raw   (dn_link_status[WID_LSB +: WID_W]),
    .limit (link_cap[WID_LSB +: WID_W]),
    .fixed (width_fix)
  );

  lnk_field_clamp #(.W(SPD_W)) u_sclamp (
    .raw   (dn_link_status[SPD_LSB +: SPD_W]),
    .limit (link_cap[SPD_LSB +: SPD_W]),
    .fixed (speed_fix)
  );

  assign take = sync_req && dn_present;

  lnk_sta_reg u_sta (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (take),
    .new_width (width_fix),
    .new_speed (speed_fix),
    .sta_q     (link_status)
  );
endmodule

// File: rtl/lnk_capsta_chk.sv
module lnk_capsta_chk
  import lnk_capsta_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [WID_W-1:0] cfg_max_width,
  input logic [SPD_W-1:0] cfg_max_speed,
  input logic             dn_present,
  input logic             sync_req,
  input logic [31:0]      link_cap,
  input logic [31:0]      link_cap2,
  input logic [STA_W-1:0] link_status
);
  assert_lbn_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    link_cap[LBN_BIT] |-> (cfg_max_width > 1 || cfg_max_speed > 1));

  assert_cap2_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_max_speed < 3) |-> (link_cap2 == 32'd0));

  assert_width_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_req && dn_present) |=>
      (link_status[WID_LSB +: WID_W] <= $past(cfg_max_width) || $past(cfg_max_width) == 0));

  assert_speed_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_req && dn_present) |=>
      (link_status[SPD_LSB +: SPD_W] <= $past(cfg_max_speed) || $past(cfg_max_speed) == 0));

  assert_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_req && dn_present) |=>
      (link_status[WID_LSB +: WID_W] != 0 || $past(cfg_max_width) == 0));

  assert_absent_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_req && !dn_present) |=> $stable(link_status));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_req |=> $stable(link_status));

  assert_upper_keep_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(link_status[STA_W-1:FLD_TOP]));
endmodule

bind lnk_capsta_top lnk_capsta_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_max_width (cfg_max_width),
  .cfg_max_speed (cfg_max_speed),
  .dn_present    (dn_present),
  .sync_req      (sync_req),
  .link_cap      (link_cap),
  .link_cap2     (link_cap2),
  .link_status   (link_status)
);

// File: tb/tb_lnk_capsta_top.sv
module tb_lnk_capsta_top;
  localparam logic [7:0] PNUM = 8'h5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cfg_max_width = 6'd1;
  logic [3:0]  cfg_max_speed = 4'd1;
  logic        dn_present = 1'b0;
  logic [15:0] dn_link_status = '0;
  logic        sync_req = 1'b0;
  logic [31:0] link_cap, link_cap2;
  logic [15:0] link_ctl2, link_status;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  lnk_capsta_top #(.PORT_NUMBER(PNUM)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_max_width(cfg_max_width),
    .cfg_max_speed(cfg_max_speed), .dn_present(dn_present),
    .dn_link_status(dn_link_status), .sync_req(sync_req),
    .link_cap(link_cap), .link_cap2(link_cap2),
    .link_ctl2(link_ctl2), .link_status(link_status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] fix_w(input logic [5:0] d, input logic [5:0] m);
    if (d > m) return m;
    if (d == 0) return 6'd1;
    return d;
  endfunction

  function automatic logic [3:0] fix_s(input logic [3:0] d, input logic [3:0] m);
    if (d > m) return m;
    if (d == 0) return 4'd1;
    return d;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [15:0] held;
    // strobe during reset must be ignored (R11)
    @(negedge clk);
    dn_present = 1'b1; dn_link_status = 16'hFFFF; sync_req = 1'b1;
    @(negedge clk);
    sync_req = 1'b0;
    chk("R6 reset value", {16'd0, link_status}, 32'h0000_0011);
    chk("R11 strobe in reset", {16'd0, link_status}, 32'h0000_0011);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 after release", {16'd0, link_status}, 32'h0000_0011);

    // R1..R5 full sweep of the configuration
    for (int w = 0; w < 64; w++) begin
      for (int s = 0; s < 16; s++) begin
        logic [31:0] e_cap, e_cap2;
        cfg_max_width = 6'(w); cfg_max_speed = 4'(s);
        #1;
        e_cap = (32'(PNUM) << 24) | (32'd1 << 10) | (32'(w) << 4) | 32'(s);
        chk("R1 cap fields", link_cap & 32'hFFCF_FFFF, e_cap);
        chk("R2 bandwidth bit", {31'd0, link_cap[21]}, {31'd0, (w > 1 || s > 1)});
        chk("R3 link-active bit", {31'd0, link_cap[20]}, {31'd0, (s > 1)});
        chk("R4 target speed", {16'd0, link_ctl2}, 32'(s));
        e_cap2 = (s >= 4) ? 32'h1E : (s >= 3) ? 32'h0E : 32'h0;
        chk("R5 speed vector", link_cap2, e_cap2);
      end
    end

    // R7..R10, R12 near-exhaustive update sweep
    foreach (cfg_max_width[i]) ; // no-op keeps loop style uniform
    for (int mi = 0; mi < 3; mi++) begin
      for (int ms = 1; ms <= 4; ms++) begin
        logic [5:0] mw;
        mw = (mi == 0) ? 6'd1 : (mi == 1) ? 6'd4 : 6'd16;
        @(negedge clk);
        cfg_max_width = mw; cfg_max_speed = 4'(ms);
        for (int dw = 0; dw < 64; dw++) begin
          for (int ds = 0; ds < 16; ds++) begin
            @(negedge clk);
            held = link_status;
            dn_present = 1'b1;
            dn_link_status = {6'(dw ^ ds), 6'(dw), 4'(ds)};
            sync_req = 1'b1;
            @(negedge clk);
            sync_req = 1'b0;
            chk("R7 width clamp", {26'd0, link_status[9:4]}, {26'd0, fix_w(6'(dw), mw)});
            chk("R8 R9 speed clamp", {28'd0, link_status[3:0]}, {28'd0, fix_s(4'(ds), 4'(ms))});
            chk("R12 upper kept", {26'd0, link_status[15:10]}, {26'd0, held[15:10]});
          end
        end
        // absent device: strobe with a different word, no change
        held = link_status;
        dn_present = 1'b0;
        dn_link_status = 16'h0000;
        sync_req = 1'b1;
        @(negedge clk);
        sync_req = 1'b0;
        chk("R10 absent ignored", {16'd0, link_status}, {16'd0, held});
        // idle: input changes without strobe
        dn_present = 1'b1;
        dn_link_status = 16'h0000;
        repeat (3) @(negedge clk);
        chk("R11 idle hold", {16'd0, link_status}, {16'd0, held});
      end
    end

    // R9 explicit zero case, R10 latency
    @(negedge clk);
    cfg_max_width = 6'd8; cfg_max_speed = 4'd3;
    dn_present = 1'b1; dn_link_status = 16'h0000; sync_req = 1'b1;
    @(negedge clk);
    sync_req = 1'b0;
    chk("R9 zero to minimum", {16'd0, link_status}, 32'h0000_0011);
    dn_link_status = 16'h0052; sync_req = 1'b1;
    #1;
    chk("R10 not before edge", {16'd0, link_status}, 32'h0000_0011);
    @(negedge clk);
    sync_req = 1'b0;
    chk("R10 one cycle result", {16'd0, link_status}, 32'h0000_0052);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule